// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. It uses a 16x bit-rate enable pulse, `tick_en`, that a divider outside the block produces. While idle it waits for a falling edge on the synchronized line. It re-checks the line eight ticks later, at the middle of the start bit. If the line is high again, the event counts as noise: the receiver drops back to idle and reports nothing. Once the start bit is confirmed, the receiver takes one sample every sixteen ticks. Each of these samples falls at the middle of a data bit, the optional parity bit or the stop bit.

At the stop-bit sample the receiver right-aligns the character and presents it on `rx_byte`. A one-clock `rx_ready` pulse marks the new character, and the parity, framing and break flags are updated at the same time. The byte and the flags then hold until the next character completes. A consumer acknowledges each character with `rd_ack`. If a character completes while the previous one is still unacknowledged, the overrun flag is raised. Character length and parity mode are captured at each start edge.

Top module: `sio_rx_sampler`

## Requirements
- R1: After reset, `rx_byte` is 0 and `rx_ready`, `err_parity`, `err_frame`, `rx_break` and `rx_overrun` are all 0.
- R2: While idle, only a high-to-low transition of the synchronized `rxd` starts reception. A line held steadily high produces no `rx_ready`.
- R3: The start bit is re-sampled on the 8th tick after the falling edge. If the line is high at that point, no `rx_ready` is produced and the receiver is idle again, ready for the next falling edge.
- R4: Every sample after the start check is taken on a `tick_en` cycle, every 16 ticks, so decoding is correct for any tick spacing in system clocks.
- R5: `len_sel` selects 5 + `len_sel` data bits (00=5 … 11=8), received least significant bit first. `rx_byte` holds them right-aligned, with the unused upper bits at 0.
- R6: `par_sel[0]`=1 enables a parity bit after the data bits, and `par_sel[1]` selects even (1) or odd (0) parity. With parity enabled, a mismatch sets `err_parity` with `rx_ready`. With parity disabled, `err_parity` is 0.
- R7: A low stop-bit sample sets `err_frame` for that character. A high stop-bit sample clears it.
- R8: `rx_break` is set when every data bit, the parity bit (if present) and the stop bit were all sampled low. `rx_break` implies `err_frame` and `rx_byte` = 0.
- R9: `rx_ready` lasts exactly one clock per character. `rx_byte` and the three error flags change only in a cycle where `rx_ready` is 1.
- R10: `rx_overrun` is set with `rx_ready` when the previous character was not acknowledged with `rd_ack`. `rd_ack` clears `rx_overrun` on the next clock.
- R11: After the stop sample the receiver waits for the line to be high before it accepts a new start. A line that stays low after a break gives exactly one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 16x bit-rate enable pulse |
| rxd | input | 1 | Asynchronous serial input, idle high |
| len_sel | input | 2 | Data length select, 5 + value bits |
| par_sel | input | 2 | Bit 0 parity enable, bit 1 even(1)/odd(0) |
| rd_ack | input | 1 | Acknowledge of the presented character |
| rx_byte | output | 8 | Received character, right-aligned |
| rx_ready | output | 1 | One-clock pulse per completed character |
| err_parity | output | 1 | Parity mismatch for the presented character |
| err_frame | output | 1 | Stop bit sampled low |
| rx_break | output | 1 | All-zero frame including stop bit |
| rx_overrun | output | 1 | Character completed before the previous one was acknowledged |

## Verification
A tick counter off by one or a phase error shifts the sample point away from the middle of the bit. At most one character later this shows up as rotated or corrupted data bits, or as a spurious framing error. A state machine that fails to return to idle after a false start or a break shows up as a missing `rx_ready` for the next frame, or as an extra one. A wrong parity or zero accumulator shows up as a wrong flag on the very next `rx_ready`. A stale acknowledge flag shows up as a wrong `rx_overrun` on the following character.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_WAITHI
    } rx_state_e;

    typedef enum logic [1:0] {
        SMP_DATA,
        SMP_PAR,
        SMP_STOP
    } smp_kind_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       par_en;
        logic       par_even;
    } rx_cfg_t;

    typedef struct packed {
        logic      valid;
        smp_kind_e kind;
        logic      lvl;
    } sample_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              par_err;
        logic              frm_err;
        logic              brk;
    } rx_result_t;

    // index of the final data bit for a length code (5..8 bits)
    function automatic logic [2:0] last_data_index(logic [1:0] code);
        return 3'd4 + {1'b0, code};
    endfunction

    // shift register fills from the top; move the character down to bit 0
    function automatic logic [CHAR_W-1:0] align_char(logic [CHAR_W-1:0] sh,
                                                      logic [1:0] code);
        return sh >> (2'd3 - code);
    endfunction

endpackage

// File: rtl/sio_rx_sync.sv
module sio_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout,
    output logic fall
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], din};
    end

    assign dout = chain[STAGES-1];
    assign fall = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/sio_rx_ctrl.sv
module sio_rx_ctrl
    import sio_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    line,
    input  logic    fall,
    input  rx_cfg_t cfg_in,
    output rx_cfg_t cfg,
    output sample_t smp
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

    rx_state_e        st;
    logic [CNT_W-1:0] tcnt;
    logic [2:0]       bcnt;
    logic             at_mid, at_end;

    assign at_mid = tick && (tcnt == MID);
    assign at_end = tick && (tcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            tcnt <= '0;
            bcnt <= '0;
            cfg  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (fall) begin
                        st   <= ST_START;
                        tcnt <= '0;
                        cfg  <= cfg_in;
                    end
                end
                ST_START: begin
                    if (at_mid) begin
                        tcnt <= '0;
                        bcnt <= '0;
                        st   <= line ? ST_IDLE : ST_DATA;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (at_end) begin
                        tcnt <= '0;
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == last_data_index(cfg.len_code))
                            st <= cfg.par_en ? ST_PAR : ST_STOP;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_end) begin
                        tcnt <= '0;
                        st   <= ST_STOP;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_end) begin
                        tcnt <= '0;
                        st   <= ST_WAITHI;
                    end else if (tick) begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_WAITHI: begin
                    if (line) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        smp.valid = 1'b0;
        smp.kind  = SMP_DATA;
        smp.lvl   = line;
        case (st)
            ST_DATA: smp.valid = at_end;
            ST_PAR: begin
                smp.valid = at_end;
                smp.kind  = SMP_PAR;
            end
            ST_STOP: begin
                smp.valid = at_end;
                smp.kind  = SMP_STOP;
            end
            default: smp.valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/sio_rx_frame.sv
module sio_rx_frame
    import sio_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rx_cfg_t    cfg,
    input  sample_t    smp,
    input  logic       ack,
    output rx_result_t res,
    output logic       ready,
    output logic       overrun
);
    logic [CHAR_W-1:0] shreg;
    logic              par_acc;
    logic              all_zero;
    logic              unread;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            par_acc  <= 1'b0;
            all_zero <= 1'b1;
            unread   <= 1'b0;
            res      <= '0;
            ready    <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (ack) begin
                unread  <= 1'b0;
                overrun <= 1'b0;
            end
            if (smp.valid) begin
                case (smp.kind)
                    SMP_DATA: begin
                        shreg    <= {smp.lvl, shreg[CHAR_W-1:1]};
                        par_acc  <= par_acc ^ smp.lvl;
                        all_zero <= all_zero & ~smp.lvl;
                    end
                    SMP_PAR: begin
                        par_acc  <= par_acc ^ smp.lvl;
                        all_zero <= all_zero & ~smp.lvl;
                    end
                    default: begin
                        res.data    <= align_char(shreg, cfg.len_code);
                        res.par_err <= cfg.par_en & (par_acc ^ ~cfg.par_even);
                        res.frm_err <= ~smp.lvl;
                        res.brk     <= all_zero & ~smp.lvl;
                        ready       <= 1'b1;
                        unread      <= 1'b1;
                        overrun     <= unread & ~ack;
                        shreg       <= '0;
                        par_acc     <= 1'b0;
                        all_zero    <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/sio_rx_sampler.sv
module sio_rx_sampler
    import sio_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        rxd,
    input  logic [1:0]  len_sel,
    input  logic [1:0]  par_sel,
    input  logic        rd_ack,
    output logic [7:0]  rx_byte,
    output logic        rx_ready,
    output logic        err_parity,
    output logic        err_frame,
    output logic        rx_break,
    output logic        rx_overrun
);
    logic       line_s, line_fall;
    rx_cfg_t    cfg_req, cfg_act;
    sample_t    smp;
    rx_result_t res;

    assign cfg_req = '{len_code: len_sel, par_en: par_sel[0], par_even: par_sel[1]};

    sio_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (line_s),
        .fall (line_fall)
    );

    sio_rx_ctrl #(.OVERSAMPLE(OVERSAMPLE)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_en),
        .line   (line_s),
        .fall   (line_fall),
        .cfg_in (cfg_req),
        .cfg    (cfg_act),
        .smp    (smp)
    );

    sio_rx_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_act),
        .smp     (smp),
        .ack     (rd_ack),
        .res     (res),
        .ready   (rx_ready),
        .overrun (rx_overrun)
    );

    assign rx_byte    = res.data;
    assign err_parity = res.par_err;
    assign err_frame  = res.frm_err;
    assign rx_break   = res.brk;
endmodule

// File: rtl/sio_rx_sampler_chk.sv
module sio_rx_sampler_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_ack,
    input logic [7:0] rx_byte,
    input logic       rx_ready,
    input logic       err_parity,
    input logic       err_frame,
    input logic       rx_break,
    input logic       rx_overrun
);
    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rx_ready |=> !rx_ready);

    p_byte_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |-> $stable(rx_byte));

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |-> $stable({err_parity, err_frame, rx_break}));

    p_break_frame_r8: assert property (@(posedge clk) disable iff (rst)
        rx_break |-> (err_frame && rx_byte == 8'h00));

    p_overrun_rise_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun) |-> rx_ready);

    p_overrun_clear_r10: assert property (@(posedge clk) disable iff (rst)
        rd_ack |=> !rx_overrun);
endmodule

bind sio_rx_sampler sio_rx_sampler_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_ack     (rd_ack),
    .rx_byte    (rx_byte),
    .rx_ready   (rx_ready),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .rx_break   (rx_break),
    .rx_overrun (rx_overrun)
);

// File: tb/test_sio_rx_sampler.sv
module test_sio_rx_sampler;
    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;

    logic       clk = 1'b0, rst = 1'b1, tick_en = 1'b0, rxd = 1'b1, rd_ack = 1'b0;
    logic [1:0] len_sel = 2'b11, par_sel = 2'b00;
    logic [7:0] rx_byte;
    logic       rx_ready, err_parity, err_frame, rx_break, rx_overrun;

    int n_checks = 0, n_fail = 0;
    int tick_div = 4;
    int rdy_cnt = 0, dbl_cnt = 0;
    logic       prev_rdy = 1'b0;
    logic [7:0] cap_byte;
    logic       cap_par, cap_frm, cap_brk, cap_ovr;

    sio_rx_sampler i_sio_rx_sampler (
        .clk(clk), .rst(rst), .tick_en(tick_en), .rxd(rxd),
        .len_sel(len_sel), .par_sel(par_sel), .rd_ack(rd_ack),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .err_parity(err_parity),
        .err_frame(err_frame), .rx_break(rx_break), .rx_overrun(rx_overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick generator: one pulse every tick_div clocks
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #1;
            ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
            tick_en = (ph == 0);
        end
    end

    // output monitor, samples mid-cycle
    always @(negedge clk) begin
        if (rx_ready) begin
            rdy_cnt  <= rdy_cnt + 1;
            cap_byte <= rx_byte;
            cap_par  <= err_parity;
            cap_frm  <= err_frame;
            cap_brk  <= rx_break;
            cap_ovr  <= rx_overrun;
            if (prev_rdy) dbl_cnt <= dbl_cnt + 1;
        end
        prev_rdy <= rx_ready;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] len_mask(input logic [1:0] code);
        return 8'hFF >> (2'd3 - code);
    endfunction

    function automatic logic par_bit(input logic [7:0] d, input logic [1:0] code,
                                     input logic even);
        logic x;
        x = ^(d & len_mask(code));
        return even ? x : ~x;
    endfunction

    task automatic hold(input logic lvl, input int clocks);
        rxd = lvl;
        repeat (clocks) @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic [1:0] code,
                              input logic [1:0] pm, input bit bad_par, input bit bad_stop);
        int bp;
        logic pb;
        bp = OSR * tick_div;
        len_sel = code;
        par_sel = pm;
        hold(1'b0, bp);
        for (int i = 0; i < 5 + int'(code); i++) hold(d[i], bp);
        if (pm[0]) begin
            pb = par_bit(d, code, pm[1]) ^ bad_par;
            hold(pb, bp);
        end
        hold(!bad_stop, bp);
        hold(1'b1, 2 * bp);
    endtask

    task automatic pulse_ack();
        rd_ack = 1'b1;
        @(posedge clk); #1;
        rd_ack = 1'b0;
    endtask

    task automatic frame_check(input logic [7:0] d, input logic [1:0] code,
                               input logic [1:0] pm, input bit bad_par, input bit bad_stop);
        int r0;
        logic [7:0] eb;
        logic pbit;
        r0 = rdy_cnt;
        send_frame(d, code, pm, bad_par, bad_stop);
        eb   = d & len_mask(code);
        pbit = pm[0] ? (par_bit(d, code, pm[1]) ^ bad_par) : 1'b0;
        check("R4 one ready per frame", rdy_cnt - r0, 1);
        check("R5 byte", cap_byte, eb);
        check("R6 parity flag", cap_par, pm[0] & bad_par);
        check("R7 framing flag", cap_frm, bad_stop);
        check("R8 break flag", cap_brk, bad_stop && eb == 8'h00 && !pbit);
        check("R10 no overrun when acked", cap_ovr, 0);
        pulse_ack();
    endtask

    initial begin
        int r0;
        void'($urandom(32'h5EED_1234));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 byte after reset", rx_byte, 0);
        check("R1 flags after reset",
              {rx_ready, err_parity, err_frame, rx_break, rx_overrun}, 0);

        // R2: steady high line
        r0 = rdy_cnt;
        hold(1'b1, 20 * OSR * tick_div);
        check("R2 no start on steady high", rdy_cnt - r0, 0);

        // R5 / R6 directed
        frame_check(8'hA5, 2'b11, 2'b00, 0, 0);
        frame_check(8'hFF, 2'b00, 2'b00, 0, 0);
        frame_check(8'h6B, 2'b01, 2'b11, 0, 0);
        frame_check(8'h35, 2'b10, 2'b01, 1, 0);
        frame_check(8'h81, 2'b11, 2'b11, 1, 0);

        // R3: false start, then a valid frame
        r0 = rdy_cnt;
        hold(1'b0, 3 * tick_div);
        hold(1'b1, 24 * OSR * tick_div);
        check("R3 false start ignored", rdy_cnt - r0, 0);
        frame_check(8'h3C, 2'b11, 2'b00, 0, 0);

        // R7: low stop with nonzero data
        frame_check(8'h5A, 2'b11, 2'b00, 0, 1);

        // R8 / R11: long break then recovery
        r0 = rdy_cnt;
        len_sel = 2'b11; par_sel = 2'b11;
        hold(1'b0, 25 * OSR * tick_div);
        check("R11 one ready for long low", rdy_cnt - r0, 1);
        check("R8 break flag", cap_brk, 1);
        check("R8 break framing", cap_frm, 1);
        check("R8 break byte", cap_byte, 0);
        hold(1'b1, 2 * OSR * tick_div);
        check("R11 still one ready after release", rdy_cnt - r0, 1);
        pulse_ack();
        frame_check(8'hC3, 2'b11, 2'b11, 0, 0);

        // R10: overrun
        send_frame(8'h11, 2'b11, 2'b00, 0, 0);
        check("R10 first unacked", cap_ovr, 0);
        send_frame(8'h22, 2'b11, 2'b00, 0, 0);
        check("R10 overrun set", cap_ovr, 1);
        check("R10 overrun byte", cap_byte, 8'h22);
        pulse_ack();
        @(negedge clk);
        check("R10 overrun cleared by ack", rx_overrun, 0);
        frame_check(8'h33, 2'b11, 2'b00, 0, 0);

        // R9: byte and flags hold while idle
        hold(1'b1, 5 * OSR * tick_div);
        @(negedge clk);
        check("R9 byte held", rx_byte, 8'h33);
        check("R9 flags held", {err_parity, err_frame, rx_break}, 0);

        // R4: other tick spacings
        tick_div = 2;
        frame_check(8'h96, 2'b11, 2'b11, 0, 0);
        frame_check(8'h0D, 2'b00, 2'b01, 0, 0);
        tick_div = 7;
        frame_check(8'h4E, 2'b10, 2'b11, 0, 0);
        frame_check(8'hE7, 2'b11, 2'b01, 1, 0);
        tick_div = 4;

        // random frames
        for (int k = 0; k < 30; k++) begin
            logic [7:0] d;
            logic [1:0] code, pm;
            bit bp, bs;
            d    = 8'($urandom);
            code = 2'($urandom);
            pm   = 2'($urandom);
            bp   = ($urandom % 6) == 0;
            bs   = ($urandom % 8) == 0;
            frame_check(d, code, pm, bp, bs);
        end

        check("R9 ready single cycle", dbl_cnt, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule